// File: doc/BRIEF.md
# Playfield Priority Colour Selector

This block sits between the bitplane shifters and the palette lookup of a raster display pipeline. On each pixel clock it takes one bit from each of up to six bitplanes and turns them into a 5-bit palette index. It also reports whether each playfield is opaque at that pixel, so that a downstream sprite merger can apply its own priority rules. The block supports two arrangements. In single playfield mode the low five planes form one colour number. In dual playfield mode the odd planes and the even planes form two independent 3-bit playfields, and an ordering control decides which one is in front.

The block also models a masking quirk of the legacy chipset. When the playfield 2 priority code is above 5 and the enhanced chipset flag is clear, certain pixels are forced to fixed colours. In single playfield mode with exactly five planes, a set fifth plane forces index 16. In dual playfield mode, every opaque playfield 2 pixel is drawn as index 0, but it keeps its opacity and its place in the ordering. The playfield 1 priority code never changes the output. Results are registered once, so each pixel appears one clock after its inputs.

Top module: `pfsel_top`

## Requirements
- R1: While rst_n is low, and on the first edge after it goes low, the registered outputs become pix_idx_o = 0, pf1_opaque_o = 0 and pf2_opaque_o = 0.
- R2: Each output reflects the inputs sampled at the previous rising clock edge. The latency is exactly one cycle.
- R3: A plane is enabled when its number (plane k = planes_i[k-1]) is at most plane_cnt_i. A plane_cnt_i value above 6 counts as 6. Disabled planes read as zero, so a count of 0 gives index 0 with both opaque flags low.
- R4: With dual_pf_i = 0, pix_idx_o = {plane5, plane4, plane3, plane2, plane1}. Plane 6 does not contribute to the index. pf1_opaque_o is set when that index is non-zero, and pf2_opaque_o stays 0.
- R5: With dual_pf_i = 1, playfield 1 uses code {plane5, plane3, plane1} and is drawn as index code (0..7). Playfield 2 uses code {plane6, plane4, plane2} and is drawn as index 8 + code.
- R6: In dual mode, pf2_front_i = 1 puts playfield 2 in front. The front playfield is shown where its code is non-zero. Otherwise the rear playfield is shown where its code is non-zero, and otherwise index 0.
- R7: In single mode, when enh_chip_i = 0, pf2_pri_i > 5 and the effective plane count is exactly 5, a set plane 5 forces index 16. A clear plane 5 leaves the normal index 0..15.
- R8: In dual mode, when enh_chip_i = 0, pf2_pri_i > 5 and at least one playfield 2 plane is enabled (count >= 2), a non-zero playfield 2 code is drawn as index 0. It still sets pf2_opaque_o, and it still hides playfield 1 when it is in front.
- R9: pf1_pri_i has no effect on any output.
- R10: With enh_chip_i = 1, a pf2_pri_i value above 5 causes no masking in either mode.
- R11: In dual mode, pf1_opaque_o and pf2_opaque_o follow the playfield codes after count gating, whether or not masking applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| planes_i | input | 6 | Current bit of each plane; bit k-1 holds plane k |
| plane_cnt_i | input | 3 | Number of enabled planes |
| dual_pf_i | input | 1 | 1 selects dual playfield mode |
| pf1_pri_i | input | 3 | Playfield 1 priority code |
| pf2_pri_i | input | 3 | Playfield 2 priority code |
| pf2_front_i | input | 1 | 1 puts playfield 2 in front of playfield 1 |
| enh_chip_i | input | 1 | 1 selects enhanced chipset behaviour (no masking) |
| pix_idx_o | output | 5 | Palette index |
| pf1_opaque_o | output | 1 | Playfield 1 is non-transparent at this pixel |
| pf2_opaque_o | output | 1 | Playfield 2 is non-transparent at this pixel |

## Verification
The assertions check a set of rules on every cycle:
- the forced index 16 under the single-mode masking condition;
- dual-mode outputs staying below 8 whenever playfield 2 is masked;
- the enhanced flag lifting the mask;
- a zero plane count blanking everything;
- pf2_opaque_o staying low in single mode.

Only the bench scenarios can show the following:
- the exact index mapping for given plane patterns;
- the interplay between the front/rear ordering and a masked playfield 2 that is still opaque;
- the exact one-cycle timing;
- the fact that the playfield 1 priority code changes nothing.

// File: rtl/pfsel_pkg.sv
package pfsel_pkg;

  parameter int unsigned PF_PLANES  = 6;
  parameter int unsigned PF_HALF    = PF_PLANES / 2;
  parameter int unsigned IDX_W      = 5;
  parameter int unsigned CNT_W      = 3;
  parameter int unsigned PRI_W      = 3;
  parameter int unsigned PRI_LIMIT  = 5;
  parameter int unsigned MASK_PLANES = 5;

  // Enable mask for planes below the clamped count.
  function automatic logic [PF_PLANES-1:0] count_mask(input logic [CNT_W-1:0] cnt);
    logic [PF_PLANES-1:0] m;
    for (int i = 0; i < PF_PLANES; i++) begin
      m[i] = (32'(i) < 32'(cnt));
    end
    return m;
  endfunction

  // Effective count after clamping to the plane total.
  function automatic logic [CNT_W-1:0] clamp_count(input logic [CNT_W-1:0] cnt);
    return (32'(cnt) > PF_PLANES) ? CNT_W'(PF_PLANES) : cnt;
  endfunction

  // Code from planes 1,3,5,... (playfield 1) or 2,4,6,... (playfield 2).
  function automatic logic [PF_HALF-1:0] pf_code(input logic [PF_PLANES-1:0] p,
                                                  input int unsigned which);
    logic [PF_HALF-1:0] c;
    for (int k = 0; k < PF_HALF; k++) begin
      c[k] = p[2*k + which];
    end
    return c;
  endfunction

  function automatic logic pri_over(input logic [PRI_W-1:0] pri);
    return 32'(pri) > PRI_LIMIT;
  endfunction

endpackage

// File: rtl/pfsel_plane_gate.sv
module pfsel_plane_gate
  import pfsel_pkg::*;
#(
  parameter int unsigned NP = PF_PLANES
) (
  input  logic [NP-1:0]    raw_i,
  input  logic [NP-1:0]    en_i,
  output logic [NP-1:0]    gated_o
);

  for (genvar g = 0; g < NP; g++) begin : g_plane
    assign gated_o[g] = raw_i[g] & en_i[g];
  end

endmodule

// File: rtl/pfsel_single_path.sv
module pfsel_single_path
  import pfsel_pkg::*;
(
  input  logic [PF_PLANES-1:0] gated_i,
  input  logic                 mask_en_i,
  output logic [IDX_W-1:0]     idx_o,
  output logic                 opaque_o
);

  localparam int unsigned TOP_PLANE = MASK_PLANES - 1;
  localparam logic [IDX_W-1:0] FORCED = IDX_W'(1) << TOP_PLANE;

  logic [IDX_W-1:0] raw_idx;

  assign raw_idx  = gated_i[IDX_W-1:0];
  assign opaque_o = |raw_idx;

  always_comb begin
    idx_o = raw_idx;
    if (mask_en_i && gated_i[TOP_PLANE]) begin
      idx_o = FORCED;
    end
  end

endmodule

// File: rtl/pfsel_dual_path.sv
module pfsel_dual_path
  import pfsel_pkg::*;
#(
  parameter logic [1:0] MASK_PF = 2'b10
) (
  input  logic [PF_PLANES-1:0] gated_i,
  input  logic [1:0]           over_i,
  input  logic [1:0]           has_plane_i,
  input  logic                 legacy_i,
  input  logic                 pf2_front_i,
  output logic [IDX_W-1:0]     idx_o,
  output logic [1:0]           opaque_o,
  output logic [1:0]           masked_o
);

  localparam int unsigned PF_COLOURS = 1 << PF_HALF;

  logic [IDX_W-1:0] colour [2];

  for (genvar f = 0; f < 2; f++) begin : g_pf
    logic [PF_HALF-1:0] code;
    assign code        = pf_code(gated_i, f);
    assign opaque_o[f] = |code;
    if (MASK_PF[f]) begin : g_mask
      assign masked_o[f] = legacy_i & over_i[f] & has_plane_i[f];
    end else begin : g_nomask
      assign masked_o[f] = 1'b0;
    end
    assign colour[f] = masked_o[f] ? '0
                     : IDX_W'(f * PF_COLOURS) + IDX_W'(code);
  end

  always_comb begin
    idx_o = '0;
    if (pf2_front_i) begin
      if (opaque_o[1])      idx_o = colour[1];
      else if (opaque_o[0]) idx_o = colour[0];
    end else begin
      if (opaque_o[0])      idx_o = colour[0];
      else if (opaque_o[1]) idx_o = colour[1];
    end
  end

endmodule

// File: rtl/pfsel_top.sv
module pfsel_top
  import pfsel_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [5:0]           planes_i,
  input  logic [2:0]           plane_cnt_i,
  input  logic                 dual_pf_i,
  input  logic [2:0]           pf1_pri_i,
  input  logic [2:0]           pf2_pri_i,
  input  logic                 pf2_front_i,
  input  logic                 enh_chip_i,
  output logic [4:0]           pix_idx_o,
  output logic                 pf1_opaque_o,
  output logic                 pf2_opaque_o
);

  logic [CNT_W-1:0]     eff_cnt;
  logic [PF_PLANES-1:0] plane_en;
  logic [PF_PLANES-1:0] gated;
  logic [1:0]           over;
  logic [1:0]           has_plane;
  logic                 legacy;

  // Named events for the checker
  logic                 legacy_single_hit;
  logic [1:0]           dual_masked;

  logic [IDX_W-1:0]     s_idx, d_idx, nxt_idx;
  logic                 s_op;
  logic [1:0]           d_op;
  logic                 nxt_op1, nxt_op2;

  assign eff_cnt  = clamp_count(plane_cnt_i);
  assign plane_en = count_mask(eff_cnt);
  assign legacy   = ~enh_chip_i;
  assign over     = {pri_over(pf2_pri_i), pri_over(pf1_pri_i)};

  for (genvar f = 0; f < 2; f++) begin : g_has
    assign has_plane[f] = |pf_code(plane_en, f);
  end

  assign legacy_single_hit = legacy & over[1] & (32'(eff_cnt) == MASK_PLANES);

  pfsel_plane_gate #(.NP(PF_PLANES)) u_gate (
    .raw_i   (planes_i),
    .en_i    (plane_en),
    .gated_o (gated)
  );

  pfsel_single_path u_single (
    .gated_i   (gated),
    .mask_en_i (legacy_single_hit),
    .idx_o     (s_idx),
    .opaque_o  (s_op)
  );

  pfsel_dual_path #(.MASK_PF(2'b10)) u_dual (
    .gated_i     (gated),
    .over_i      (over),
    .has_plane_i (has_plane),
    .legacy_i    (legacy),
    .pf2_front_i (pf2_front_i),
    .idx_o       (d_idx),
    .opaque_o    (d_op),
    .masked_o    (dual_masked)
  );

  always_comb begin
    if (dual_pf_i) begin
      nxt_idx = d_idx;
      nxt_op1 = d_op[0];
      nxt_op2 = d_op[1];
    end else begin
      nxt_idx = s_idx;
      nxt_op1 = s_op;
      nxt_op2 = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_idx_o    <= '0;
      pf1_opaque_o <= 1'b0;
      pf2_opaque_o <= 1'b0;
    end else begin
      pix_idx_o    <= nxt_idx;
      pf1_opaque_o <= nxt_op1;
      pf2_opaque_o <= nxt_op2;
    end
  end

endmodule

// File: rtl/pfsel_chk.sv
module pfsel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] planes_i,
  input logic [2:0] plane_cnt_i,
  input logic       dual_pf_i,
  input logic [2:0] pf2_pri_i,
  input logic       pf2_front_i,
  input logic       enh_chip_i,
  input logic [4:0] pix_idx_o,
  input logic       pf1_opaque_o,
  input logic       pf2_opaque_o,
  input logic       legacy_single_hit,
  input logic [1:0] dual_masked
);

  a_r7_force16: assert property (@(posedge clk) disable iff (!rst_n)
    (!enh_chip_i && pf2_pri_i > 3'd5 && plane_cnt_i == 3'd5 && !dual_pf_i && planes_i[4])
    |=> pix_idx_o == 5'd16);

  a_r8_pf2_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (!enh_chip_i && dual_pf_i && pf2_pri_i > 3'd5 && plane_cnt_i >= 3'd2)
    |=> pix_idx_o < 5'd8);

  a_r10_no_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_chip_i && !dual_pf_i && plane_cnt_i == 3'd5 && planes_i[4:0] == 5'h1f)
    |=> pix_idx_o == 5'd31);

  a_r3_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (plane_cnt_i == 3'd0) |=> (pix_idx_o == 5'd0 && !pf1_opaque_o && !pf2_opaque_o));

  a_r4_single_no_pf2: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_pf_i |=> !pf2_opaque_o);

  a_r8_mask_keeps_opaque: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_pf_i && dual_masked[1] && planes_i[1]) |=> pf2_opaque_o);

  a_r7_hit_legacy_only: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_single_hit |-> (!enh_chip_i && pf2_pri_i > 3'd5));

  a_r9_pf1_never_masks: assert property (@(posedge clk) disable iff (!rst_n)
    dual_masked[0] == 1'b0);

  a_r6_pf1_front_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_pf_i && !pf2_front_i && planes_i[0] && plane_cnt_i != 3'd0)
    |=> (pix_idx_o != 5'd0 && pix_idx_o < 5'd8));

endmodule

bind pfsel_top pfsel_chk u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .planes_i          (planes_i),
  .plane_cnt_i       (plane_cnt_i),
  .dual_pf_i         (dual_pf_i),
  .pf2_pri_i         (pf2_pri_i),
  .pf2_front_i       (pf2_front_i),
  .enh_chip_i        (enh_chip_i),
  .pix_idx_o         (pix_idx_o),
  .pf1_opaque_o      (pf1_opaque_o),
  .pf2_opaque_o      (pf2_opaque_o),
  .legacy_single_hit (legacy_single_hit),
  .dual_masked       (dual_masked)
);

// File: tb/sim_pfsel_top.sv
`timescale 1ns/1ps
module sim_pfsel_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] planes;
  logic [2:0] cnt;
  logic       dual;
  logic [2:0] p1pri, p2pri;
  logic       front, enh;
  logic [4:0] idx;
  logic       op1, op2;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  pfsel_top u0 (
    .clk (clk), .rst_n (rst_n), .planes_i (planes), .plane_cnt_i (cnt),
    .dual_pf_i (dual), .pf1_pri_i (p1pri), .pf2_pri_i (p2pri),
    .pf2_front_i (front), .enh_chip_i (enh),
    .pix_idx_o (idx), .pf1_opaque_o (op1), .pf2_opaque_o (op2)
  );

  // Independent reference, written per requirement.
  function automatic logic [6:0] model(input logic [5:0] p, input logic [2:0] c,
                                       input logic d, input logic [2:0] pri2,
                                       input logic fr, input logic e);
    int ec, a, b, i1, cb;
    logic [5:0] g;
    logic o1, o2;
    ec = (c > 6) ? 6 : c;
    for (int k = 0; k < 6; k++) g[k] = p[k] && (k < ec);
    if (!d) begin
      i1 = 16*g[4] + 8*g[3] + 4*g[2] + 2*g[1] + g[0];
      o1 = (i1 != 0);
      if (!e && pri2 >= 6 && ec == 5 && g[4]) i1 = 16;
      return {1'b0, o1, 5'(i1)};
    end
    a  = g[0] + 2*g[2] + 4*g[4];
    b  = g[1] + 2*g[3] + 4*g[5];
    o1 = (a != 0);
    o2 = (b != 0);
    cb = (!e && pri2 >= 6 && ec >= 2) ? 0 : 8 + b;
    if (fr) i1 = o2 ? cb : (o1 ? a : 0);
    else    i1 = o1 ? a : (o2 ? cb : 0);
    return {o2, o1, 5'(i1)};
  endfunction

  task automatic check(input string tag, input logic [4:0] e_idx,
                       input logic e1, input logic e2);
    n_tests++;
    if (idx !== e_idx || op1 !== e1 || op2 !== e2) begin
      n_fail++;
      $display("FAIL %s: got idx=%0d op1=%0b op2=%0b expected idx=%0d op1=%0b op2=%0b",
               tag, idx, op1, op2, e_idx, e1, e2);
    end
  endtask

  // Drive at a falling edge, sample at the next falling edge.
  task automatic apply(input logic [5:0] p, input logic [2:0] c, input logic d,
                       input logic [2:0] pri1, input logic [2:0] pri2,
                       input logic fr, input logic e);
    planes = p; cnt = c; dual = d; p1pri = pri1; p2pri = pri2; front = fr; enh = e;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    apply(6'h3f, 3'd6, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0);
    check("R1 reset", 5'd0, 1'b0, 1'b0);
    apply(6'h3f, 3'd6, 1'b1, 3'd0, 3'd0, 1'b1, 1'b0);
    check("R1 reset held", 5'd0, 1'b0, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_latency;
    apply(6'b000011, 3'd6, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0);
    planes = 6'b000101;
    #1;
    check("R2 old value before edge", 5'd3, 1'b1, 1'b0);
    @(negedge clk);
    check("R2 new value after edge", 5'd5, 1'b1, 1'b0);
  endtask

  task automatic t_count;
    apply(6'h3f, 3'd3, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0);
    check("R3 three planes", 5'd7, 1'b1, 1'b0);
    apply(6'h3f, 3'd7, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0);
    check("R3 count clamp", 5'd31, 1'b1, 1'b0);
    apply(6'h3f, 3'd0, 1'b1, 3'd0, 3'd0, 1'b0, 1'b0);
    check("R3 zero planes", 5'd0, 1'b0, 1'b0);
  endtask

  task automatic t_single;
    apply(6'b010110, 3'd5, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0);
    check("R4 single index", 5'd22, 1'b1, 1'b0);
    apply(6'b100001, 3'd6, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0);
    check("R4 plane six unused", 5'd1, 1'b1, 1'b0);
  endtask

  task automatic t_dual;
    apply(6'b000101, 3'd6, 1'b1, 3'd0, 3'd0, 1'b0, 1'b0);
    check("R5 pf1 only", 5'd3, 1'b1, 1'b0);
    apply(6'b100010, 3'd6, 1'b1, 3'd0, 3'd0, 1'b0, 1'b0);
    check("R5 pf2 only", 5'd13, 1'b0, 1'b1);
    apply(6'h3f, 3'd6, 1'b1, 3'd0, 3'd0, 1'b0, 1'b0);
    check("R6 pf1 in front", 5'd7, 1'b1, 1'b1);
    apply(6'h3f, 3'd6, 1'b1, 3'd0, 3'd0, 1'b1, 1'b0);
    check("R6 pf2 in front", 5'd15, 1'b1, 1'b1);
    apply(6'b000001, 3'd6, 1'b1, 3'd0, 3'd0, 1'b1, 1'b0);
    check("R6 front transparent", 5'd1, 1'b1, 1'b0);
  endtask

  task automatic t_legacy_single;
    apply(6'b011111, 3'd5, 1'b0, 3'd0, 3'd7, 1'b0, 1'b0);
    check("R7 plane5 set forces 16", 5'd16, 1'b1, 1'b0);
    apply(6'b001111, 3'd5, 1'b0, 3'd0, 3'd6, 1'b0, 1'b0);
    check("R7 plane5 clear normal", 5'd15, 1'b1, 1'b0);
    apply(6'b011111, 3'd5, 1'b0, 3'd0, 3'd5, 1'b0, 1'b0);
    check("R7 code 5 no mask", 5'd31, 1'b1, 1'b0);
    apply(6'b011010, 3'd6, 1'b0, 3'd0, 3'd7, 1'b0, 1'b0);
    check("R7 six planes no mask", 5'd26, 1'b1, 1'b0);
  endtask

  task automatic t_legacy_dual;
    apply(6'b000011, 3'd2, 1'b1, 3'd0, 3'd6, 1'b1, 1'b0);
    check("R8 masked pf2 in front", 5'd0, 1'b1, 1'b1);
    apply(6'b000011, 3'd2, 1'b1, 3'd0, 3'd6, 1'b0, 1'b0);
    check("R8 pf1 in front of masked pf2", 5'd1, 1'b1, 1'b1);
    apply(6'b001010, 3'd4, 1'b1, 3'd0, 3'd7, 1'b0, 1'b0);
    check("R11 masked pf2 alone opaque", 5'd0, 1'b0, 1'b1);
    apply(6'b000011, 3'd1, 1'b1, 3'd0, 3'd7, 1'b1, 1'b0);
    check("R8 no pf2 plane", 5'd1, 1'b1, 1'b0);
  endtask

  task automatic t_pf1_pri;
    apply(6'b011111, 3'd5, 1'b0, 3'd7, 3'd0, 1'b0, 1'b0);
    check("R9 pf1 code 7 single", 5'd31, 1'b1, 1'b0);
    apply(6'b000011, 3'd6, 1'b1, 3'd7, 3'd0, 1'b1, 1'b0);
    check("R9 pf1 code 7 dual", 5'd9, 1'b1, 1'b1);
  endtask

  task automatic t_enhanced;
    apply(6'b011111, 3'd5, 1'b0, 3'd0, 3'd7, 1'b0, 1'b1);
    check("R10 single no mask", 5'd31, 1'b1, 1'b0);
    apply(6'b000010, 3'd6, 1'b1, 3'd0, 3'd7, 1'b0, 1'b1);
    check("R10 dual no mask", 5'd9, 1'b0, 1'b1);
  endtask

  task automatic t_sweep;
    logic [31:0] lf = 32'h1ace_b00c;
    for (int n = 0; n < 400; n++) begin
      logic [6:0] exp_v;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      apply(lf[5:0], lf[8:6], lf[9], lf[12:10], lf[15:13], lf[16], lf[17]);
      exp_v = model(lf[5:0], lf[8:6], lf[9], lf[15:13], lf[16], lf[17]);
      check("R4 R5 R6 R7 R8 R10 sweep", exp_v[4:0], exp_v[5], exp_v[6]);
    end
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    planes = '0; cnt = '0; dual = 1'b0; p1pri = '0; p2pri = '0; front = 1'b0; enh = 1'b0;
    @(negedge clk);
    t_reset();
    t_latency();
    t_count();
    t_single();
    t_dual();
    t_legacy_single();
    t_legacy_dual();
    t_pf1_pri();
    t_enhanced();
    t_sweep();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule